// File: doc/BRIEF.md
# Downstream Bus Activity Monitor

This block sits on the shared downstream side of a two-master bus selector. It watches the downstream clock and data lines, passes each through its own synchronizer, and tracks whether a transfer is in progress. A START sets the busy state and a STOP returns the bus to idle. The master arbiter sends a one-cycle strobe whenever the selected upstream channel changes. If that strobe arrives while a transfer is open, the block latches a flag. The flag tells the new owner that the slaves may be stuck mid-byte, so the owner must run its own recovery sequence on the bus.

The monitor only reports when the selector's own recovery sequence is switched off. When that sequence is in use, the downstream bus is re-initialized before every handover, so a mid-transfer switch needs no report. An upstream owner can also mask the report. A masked switch records nothing. The latched flag stays set until a clear strobe arrives.

Top module: `bus_switch_watch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `bus_busy` is 0 and `recov_irq` is inactive (0 with the default active-high polarity).
- R2: A START sets `bus_busy` to 1. A START is the synchronized data line falling while the synchronized clock line is high in the current sample and in the previous one. `bus_busy` rises on the third rising clock edge after the raw data line falls: two synchronizer stages plus one state register.
- R3: A STOP clears `bus_busy` to 0. A STOP is the synchronized data line rising while the clock line is high in both samples, with the same three-edge latency as R2.
- R4: `bus_busy` keeps its value when no START or STOP occurs. This covers a data change while the clock line is low, a clock change with steady data, a repeated START while busy, and a steady high bus while idle.
- R5: A `chan_switch` strobe sets the latched flag on the same rising edge if all of the following hold: `bus_busy` is 1, `int_recov_on` is 0 and `irq_mask` is 0. `recov_irq` then reads 1 after that edge.
- R6: A `chan_switch` strobe while `bus_busy` is 0 leaves the flag unchanged.
- R7: While `int_recov_on` is 1, a `chan_switch` strobe never sets the flag, even with the bus busy.
- R8: While `irq_mask` is 1, a `chan_switch` strobe never sets the flag and nothing is recorded. Dropping the mask afterwards still shows `recov_irq` at 0. Masking does not hide a flag that is already set.
- R9: Once set, the flag holds through later START, STOP and switch strobes. It is cleared on the rising edge where `irq_clear` is 1 and no setting switch occurs.
- R10: If a setting switch and `irq_clear` fall on the same edge, the flag ends up set.
- R11: A switch strobe tests the busy state as registered before that edge. A strobe in the cycle where a START is being detected does not set the flag. A strobe one cycle later does set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ds_scl | input | 1 | Raw downstream clock line level |
| ds_sda | input | 1 | Raw downstream data line level |
| chan_switch | input | 1 | One-cycle strobe from the arbiter when the selected channel changes |
| int_recov_on | input | 1 | 1 when the built-in recovery sequence is in use, which disables reporting |
| irq_mask | input | 1 | 1 blocks the flag from being set |
| irq_clear | input | 1 | Strobe that clears the latched flag |
| bus_busy | output | 1 | 1 between a START and the following STOP |
| recov_irq | output | 1 | Latched external-recovery request (polarity set by a parameter, active high by default) |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a channel-switch strobe and a START that is still passing through the detector. The second pair is a setting switch and a clear strobe. The bench times the raw data fall so that the strobe lands exactly in the detection cycle, and expects no flag. It then repeats the strobe one cycle later and expects the flag. The switch-plus-clear collision is driven from the vector table with the bus busy, and the flag is expected to survive.

// File: rtl/bsw_pkg.sv
package bsw_pkg;

   typedef enum logic {
      LINE_IDLE = 1'b0,
      LINE_BUSY = 1'b1
   } line_state_e;

   typedef struct packed {
      logic start;
      logic stop;
   } cond_t;

endpackage

// File: rtl/bsw_sync.sv
module bsw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_stage_chk
      $error("bsw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[i] <= RST_VAL;
         else if (i == 0)
            chain[i] <= d;
         else
            chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q = chain[TOP];

endmodule

// File: rtl/bsw_cond_detect.sv
module bsw_cond_detect
   import bsw_pkg::*;
#(
   parameter bit STRICT_SCL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_s,
   input  logic  sda_s,
   output cond_t cond
);
   logic scl_q, sda_q, scl_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   if (STRICT_SCL) begin : g_strict
      assign scl_ok = scl_s & scl_q;
   end else begin : g_loose
      assign scl_ok = scl_s;
   end

   assign cond.start = scl_ok &  sda_q & ~sda_s;
   assign cond.stop  = scl_ok & ~sda_q &  sda_s;

   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond.start |=> !cond.start);

   // R3
   stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond.stop |=> !cond.stop);

endmodule

// File: rtl/bsw_busy_track.sv
module bsw_busy_track
   import bsw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  cond_t       cond,
   output line_state_e state
);
   line_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         LINE_IDLE: if (cond.start) state_nx = LINE_BUSY;
         LINE_BUSY: if (cond.stop)  state_nx = LINE_IDLE;
         default:   state_nx = LINE_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= LINE_IDLE;
      else
         state <= state_nx;
   end

endmodule

// File: rtl/bsw_flag_ctl.sv
module bsw_flag_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic switch_stb,
   input  logic busy,
   input  logic recov_on,
   input  logic mask,
   input  logic clear,
   output logic flag
);
   logic arm;

   assign arm = switch_stb & busy & ~recov_on & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (arm)
         flag <= 1'b1;
      else if (clear)
         flag <= 1'b0;
   end

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clear |=> flag);

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear && !switch_stb |=> !flag);

   // R6
   idle_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && !busy |=> !flag);

   // R7
   recov_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && recov_on |=> !flag);

   // R8
   mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag && mask |=> !flag);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_stb && busy && !recov_on && !mask |=> flag);

endmodule

// File: rtl/bus_switch_watch.sv
module bus_switch_watch
   import bsw_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit STRICT_SCL     = 1'b1,
   parameter bit IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ds_scl,
   input  logic ds_sda,
   input  logic chan_switch,
   input  logic int_recov_on,
   input  logic irq_mask,
   input  logic irq_clear,
   output logic bus_busy,
   output logic recov_irq
);
   if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_param_chk
      $error("bus_switch_watch: SYNC_STAGES must lie in 2..8");
   end

   logic        scl_s, sda_s, flag;
   cond_t       cond;
   line_state_e state;

   bsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(ds_scl), .q(scl_s));

   bsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(ds_sda), .q(sda_s));

   bsw_cond_detect #(.STRICT_SCL(STRICT_SCL)) u_detect (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .cond(cond));

   bsw_busy_track u_track (
      .clk(clk), .rst_n(rst_n), .cond(cond), .state(state));

   assign bus_busy = (state == LINE_BUSY);

   bsw_flag_ctl u_flag (
      .clk(clk), .rst_n(rst_n), .switch_stb(chan_switch), .busy(bus_busy),
      .recov_on(int_recov_on), .mask(irq_mask), .clear(irq_clear),
      .flag(flag));

   if (IRQ_ACTIVE_LOW) begin : g_irq_low
      assign recov_irq = ~flag;
   end else begin : g_irq_high
      assign recov_irq = flag;
   end

   // R2
   busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond.start |=> bus_busy);

   // R3
   idle_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond.stop |=> !bus_busy);

   // R4
   busy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cond.start && !cond.stop |=> $stable(bus_busy));

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(chan_switch) && $past(bus_busy));

endmodule

// File: tb/bus_switch_watch_test.sv
`timescale 1ns/1ps
module bus_switch_watch_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ds_scl = 1'b1, ds_sda = 1'b1;
   logic chan_switch = 1'b0, int_recov_on = 1'b0, irq_mask = 1'b0, irq_clear = 1'b0;
   logic bus_busy, recov_irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bus_switch_watch uut (
      .clk(clk), .rst_n(rst_n), .ds_scl(ds_scl), .ds_sda(ds_sda),
      .chan_switch(chan_switch), .int_recov_on(int_recov_on),
      .irq_mask(irq_mask), .irq_clear(irq_clear),
      .bus_busy(bus_busy), .recov_irq(recov_irq));

   // fields: scl sda sw clr recov mask exp_busy exp_irq
   localparam int NV = 19;
   localparam logic [7:0] VEC [NV] = '{
      8'b11_0000_00, // R1  idle bus after reset
      8'b11_1000_00, // R6  switch while idle
      8'b10_0000_10, // R2  START
      8'b10_1010_10, // R7  switch with internal recovery on
      8'b10_1001_10, // R8  switch while masked
      8'b10_0000_10, // R8  unmasked: nothing recorded
      8'b00_0000_10, // R4  clock falls
      8'b01_0000_10, // R4  data rises with clock low
      8'b11_0000_10, // R4  clock rises, data steady
      8'b10_0000_10, // R4  repeated START while busy
      8'b10_1000_11, // R5  switch mid-transfer
      8'b11_0000_01, // R3  STOP, R9 flag held
      8'b11_1000_01, // R9  idle switch, flag held
      8'b11_0100_00, // R9  clear
      8'b10_0000_10, // R2  new START
      8'b10_1100_11, // R10 switch and clear together
      8'b10_0100_10, // R9  clear while busy
      8'b11_0000_00, // R3  STOP
      8'b11_0000_00  // R4  steady high while idle
   };
   localparam int VREQ [NV] = '{1,6,2,7,8,8,4,4,4,4,5,3,9,9,2,10,9,3,4};

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R1: reset state, with the lines held at a START pattern
      ds_sda = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "busy in reset", bus_busy, 1'b0);
      chk("R1", "irq in reset", recov_irq, 1'b0);
      ds_sda = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      chk("R1", "busy after reset", bus_busy, 1'b0);
      chk("R1", "irq after reset", recov_irq, 1'b0);

      for (int v = 0; v < NV; v++) begin
         ds_scl = VEC[v][7];
         ds_sda = VEC[v][6];
         int_recov_on = VEC[v][3];
         irq_mask = VEC[v][2];
         repeat (4) step();
         chan_switch = VEC[v][5];
         irq_clear = VEC[v][4];
         step();
         chan_switch = 1'b0;
         irq_clear = 1'b0;
         chk($sformatf("R%0d vec%0d", VREQ[v], v), "busy", bus_busy, VEC[v][1]);
         chk($sformatf("R%0d vec%0d", VREQ[v], v), "irq", recov_irq, VEC[v][0]);
      end

      // R2 latency and R11 switch in the START detection cycle
      int_recov_on = 1'b0;
      irq_mask = 1'b0;
      ds_sda = 1'b0;
      step();
      chk("R2", "busy after edge 1", bus_busy, 1'b0);
      step();
      chk("R2", "busy after edge 2", bus_busy, 1'b0);
      chan_switch = 1'b1;
      step();
      chk("R2", "busy after edge 3", bus_busy, 1'b1);
      chk("R11", "irq when switch meets detection", recov_irq, 1'b0);
      step();
      chan_switch = 1'b0;
      chk("R11", "irq when switch follows detection", recov_irq, 1'b1);

      // R8: mask does not hide an already set flag
      irq_mask = 1'b1;
      step();
      chk("R8", "set flag while masked", recov_irq, 1'b1);
      irq_clear = 1'b1;
      step();
      irq_clear = 1'b0;
      irq_mask = 1'b0;
      chk("R9", "clear strobe", recov_irq, 1'b0);

      // R3: STOP latency
      ds_sda = 1'b1;
      step();
      step();
      chk("R3", "busy after STOP edge 2", bus_busy, 1'b1);
      step();
      chk("R3", "busy after STOP edge 3", bus_busy, 1'b0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule